// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of the cache-line misses that a non-blocking cache has sent to memory and that have not yet come back. A primary miss takes a free entry and produces exactly one memory request. That request carries the entry index as its transaction ID. A later miss to the same line does not go to memory again. It joins the live entry as an extra waiter. Misses to different lines take different entries and are issued back to back, so their memory latencies overlap.

Responses may return in any order. When the response for an entry arrives, the entry delivers one completion per waiter, one per cycle and in the order the waiters attached, and then it frees itself. A fence request blocks all new misses until every live entry has retired. The block then acknowledges the fence with a single-cycle pulse. The cache presents line addresses (byte address bits 31:6 for 64-byte lines). The `stall` output tells it when a miss was not taken, so that it can present the miss again.

Top module: `mshrFile`

## Requirements
- R1: After reset no entry is live: `memReqValid`, `doneValid`, `fenceAck` and `stall` are all low.
- R2: A miss to a line with no live entry is accepted and produces exactly one memory request with `memReqLine` equal to that line. No further request for that line is made while the entry is live.
- R3: A miss to a line whose live entry has not yet received its response is accepted as an extra waiter and produces no memory request.
- R4: An entry holds at most 4 waiters. A fifth miss to that line sees `stall` high and is not accepted.
- R5: With all 16 entries live, a miss to a line that is not present sees `stall` high. A miss that merges into a live entry is still accepted.
- R6: Requests for different lines are issued without waiting for earlier responses, so up to 16 can be outstanding at once.
- R7: A response names an entry by `memRspId`, which is the `memReqId` of its request. Responses may arrive in any order.
- R8: Every accepted waiter gets exactly one completion carrying its own tag and destination. Completions appear at most one per cycle, and those of one entry appear in attach order.
- R9: An entry frees itself in the cycle after its last completion. A later miss to the same line then allocates anew and issues a fresh request.
- R10: A miss that arrives in the same cycle as the response for its line merges into the live entry. It gets its own completion and causes no second request.
- R11: A miss to a line whose response has arrived but whose completions are still pending sees `stall` high until the entry has freed itself.
- R12: `fenceReq` is a one-cycle request. From that cycle until the acknowledge, every miss sees `stall` high. `fenceAck` is a single-cycle pulse that occurs only when no entry is live. A fence raised with nothing outstanding is acknowledged within a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | A miss is presented this cycle |
| missLine | input | 26 | Line address of the miss |
| missTag | input | 6 | Requester tag |
| missDest | input | 5 | Destination register for the returned data |
| stall | output | 1 | The presented miss is not accepted this cycle |
| memReqValid | output | 1 | Memory request pending |
| memReqReady | input | 1 | Memory takes the request this cycle |
| memReqLine | output | 26 | Line address of the request |
| memReqId | output | 4 | Transaction ID of the request (entry index) |
| memRspValid | input | 1 | Memory response this cycle |
| memRspId | input | 4 | Transaction ID of the response |
| doneValid | output | 1 | A completion is delivered this cycle |
| doneTag | output | 6 | Tag of the completed waiter |
| doneDest | output | 5 | Destination of the completed waiter |
| fenceReq | input | 1 | One-cycle fence request |
| fenceAck | output | 1 | One-cycle fence acknowledge |

## Verification
The tricky overlap is a new miss to a line arriving in the same cycle as that line's memory response. At that point the entry is still live and not yet marked as returned. The bench holds the memory model, forces the response by hand in exactly the cycle it drives the miss, and then expects the miss to be accepted, to get its own completion after the original waiter, and to leave the line's request count at one. A second overlap is a fence request arriving in the same cycle as a miss. The bench expects `stall` in that same cycle, and it checks at every acknowledge that its own count of outstanding waiters is zero.

// File: rtl/mshrPkg.sv
package mshrPkg;
  parameter int NUM_ENTRIES = 16;
  parameter int ADDR_W      = 32;
  parameter int LINE_BYTES  = 64;
  parameter int MAX_WAITERS = 4;
  parameter int TAG_W       = 6;
  parameter int DEST_W      = 5;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(NUM_ENTRIES);
  localparam int CNT_W  = $clog2(MAX_WAITERS + 1);
  localparam int WPOS_W = $clog2(MAX_WAITERS);

  typedef struct packed {
    logic             alloc;
    logic [IDX_W-1:0] allocIdx;
    logic             merge;
    logic [IDX_W-1:0] mergeIdx;
    logic             issue;
    logic [IDX_W-1:0] issueIdx;
    logic             rsp;
    logic [IDX_W-1:0] rspIdx;
    logic             drain;
    logic [IDX_W-1:0] drainIdx;
  } strobeT;

  typedef enum logic [1:0] {FENCE_IDLE, FENCE_WAIT, FENCE_ACK} fenceStateT;
endpackage

// File: rtl/mshrData.sv
module mshrData
  import mshrPkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  strobeT                 st,
  input  logic [LINE_W-1:0]      missLine,
  input  logic [TAG_W-1:0]       missTag,
  input  logic [DEST_W-1:0]      missDest,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] issuedVec,
  output logic [NUM_ENTRIES-1:0] respVec,
  output logic [NUM_ENTRIES-1:0] lineEqVec,
  output logic [NUM_ENTRIES-1:0] waitFullVec,
  output logic [LINE_W-1:0]      reqLine,
  output logic [TAG_W-1:0]       doneTag,
  output logic [DEST_W-1:0]      doneDest
);
  logic [LINE_W-1:0] lineArr     [NUM_ENTRIES];
  logic [TAG_W-1:0]  doneTagArr  [NUM_ENTRIES];
  logic [DEST_W-1:0] doneDestArr [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    logic              live, sent, back;
    logic [LINE_W-1:0] lineReg;
    logic [CNT_W-1:0]  waitCnt, doneCnt;
    logic [TAG_W-1:0]  wTag  [MAX_WAITERS];
    logic [DEST_W-1:0] wDest [MAX_WAITERS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live    <= 1'b0;
        sent    <= 1'b0;
        back    <= 1'b0;
        lineReg <= '0;
        waitCnt <= '0;
        doneCnt <= '0;
      end else begin
        if (st.alloc && st.allocIdx == IDX_W'(e)) begin
          live    <= 1'b1;
          sent    <= 1'b0;
          back    <= 1'b0;
          lineReg <= missLine;
          waitCnt <= CNT_W'(1);
          doneCnt <= '0;
        end else if (st.merge && st.mergeIdx == IDX_W'(e)) begin
          waitCnt <= waitCnt + CNT_W'(1);
        end
        if (st.issue && st.issueIdx == IDX_W'(e)) sent <= 1'b1;
        if (st.rsp && st.rspIdx == IDX_W'(e) && live && sent) back <= 1'b1;
        if (st.drain && st.drainIdx == IDX_W'(e)) begin
          if ((doneCnt + CNT_W'(1)) == waitCnt) live <= 1'b0;
          else doneCnt <= doneCnt + CNT_W'(1);
        end
      end
    end

    // waiter slots carry no reset: a slot is read only below waitCnt
    always_ff @(posedge clk) begin
      if (st.alloc && st.allocIdx == IDX_W'(e)) begin
        wTag[0]  <= missTag;
        wDest[0] <= missDest;
      end else if (st.merge && st.mergeIdx == IDX_W'(e)) begin
        wTag[waitCnt[WPOS_W-1:0]]  <= missTag;
        wDest[waitCnt[WPOS_W-1:0]] <= missDest;
      end
    end

    assign validVec[e]    = live;
    assign issuedVec[e]   = sent;
    assign respVec[e]     = back;
    assign lineEqVec[e]   = (lineReg == missLine);
    assign waitFullVec[e] = (waitCnt == CNT_W'(MAX_WAITERS));
    assign lineArr[e]     = lineReg;
    assign doneTagArr[e]  = wTag[doneCnt[WPOS_W-1:0]];
    assign doneDestArr[e] = wDest[doneCnt[WPOS_W-1:0]];
  end

  assign reqLine  = lineArr[st.issueIdx];
  assign doneTag  = doneTagArr[st.drainIdx];
  assign doneDest = doneDestArr[st.drainIdx];
endmodule

// File: rtl/mshrCtrl.sv
module mshrCtrl
  import mshrPkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   missValid,
  input  logic                   fenceReq,
  input  logic                   memReqReady,
  input  logic                   memRspValid,
  input  logic [IDX_W-1:0]       memRspId,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] issuedVec,
  input  logic [NUM_ENTRIES-1:0] respVec,
  input  logic [NUM_ENTRIES-1:0] lineEqVec,
  input  logic [NUM_ENTRIES-1:0] waitFullVec,
  output strobeT                 st,
  output logic                   stall,
  output logic                   memReqValid,
  output logic                   doneValid,
  output logic                   fenceAck
);
  function automatic logic [IDX_W-1:0] firstSet(input logic [NUM_ENTRIES-1:0] vec);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  fenceStateT fState;
  logic [NUM_ENTRIES-1:0] hitVec, pendVec, readyVec;
  logic [IDX_W-1:0] hitIdx;
  logic hit, hitBlocked, full, fenceHold, refuse, accept;

  always_comb begin
    hitVec     = validVec & lineEqVec;
    hit        = |hitVec;
    hitIdx     = firstSet(hitVec);
    hitBlocked = waitFullVec[hitIdx] || respVec[hitIdx];
    full       = &validVec;
    fenceHold  = fenceReq || (fState == FENCE_WAIT);
    refuse     = fenceHold || (hit ? hitBlocked : full);
    accept     = missValid && !refuse;
    stall      = missValid && refuse;

    pendVec     = validVec & ~issuedVec;
    readyVec    = validVec & respVec;
    memReqValid = |pendVec;
    doneValid   = |readyVec;

    st          = '0;
    st.alloc    = accept && !hit;
    st.allocIdx = firstSet(~validVec);
    st.merge    = accept && hit;
    st.mergeIdx = hitIdx;
    st.issue    = memReqValid && memReqReady;
    st.issueIdx = firstSet(pendVec);
    st.rsp      = memRspValid;
    st.rspIdx   = memRspId;
    st.drain    = doneValid;
    st.drainIdx = firstSet(readyVec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fState <= FENCE_IDLE;
    else begin
      case (fState)
        FENCE_IDLE: if (fenceReq) fState <= FENCE_WAIT;
        FENCE_WAIT: if (validVec == '0) fState <= FENCE_ACK;
        FENCE_ACK:  fState <= fenceReq ? FENCE_WAIT : FENCE_IDLE;
        default:    fState <= FENCE_IDLE;
      endcase
    end
  end

  assign fenceAck = (fState == FENCE_ACK);
endmodule

// File: rtl/mshrFile.sv
module mshrFile
  import mshrPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              missValid,
  input  logic [LINE_W-1:0] missLine,
  input  logic [TAG_W-1:0]  missTag,
  input  logic [DEST_W-1:0] missDest,
  output logic              stall,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [LINE_W-1:0] memReqLine,
  output logic [IDX_W-1:0]  memReqId,
  input  logic              memRspValid,
  input  logic [IDX_W-1:0]  memRspId,
  output logic              doneValid,
  output logic [TAG_W-1:0]  doneTag,
  output logic [DEST_W-1:0] doneDest,
  input  logic              fenceReq,
  output logic              fenceAck
);
  strobeT st;
  logic [NUM_ENTRIES-1:0] validVec, issuedVec, respVec, lineEqVec, waitFullVec;

  mshrCtrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .missValid(missValid), .fenceReq(fenceReq),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspId(memRspId),
    .validVec(validVec), .issuedVec(issuedVec), .respVec(respVec),
    .lineEqVec(lineEqVec), .waitFullVec(waitFullVec), .st(st), .stall(stall),
    .memReqValid(memReqValid), .doneValid(doneValid), .fenceAck(fenceAck)
  );

  mshrData u_data (
    .clk(clk), .rst_n(rst_n), .st(st), .missLine(missLine), .missTag(missTag),
    .missDest(missDest), .validVec(validVec), .issuedVec(issuedVec),
    .respVec(respVec), .lineEqVec(lineEqVec), .waitFullVec(waitFullVec),
    .reqLine(memReqLine), .doneTag(doneTag), .doneDest(doneDest)
  );

  assign memReqId = st.issueIdx;
endmodule

// File: rtl/mshrFileChecker.sv
module mshrFileChecker
  import mshrPkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   missValid,
  input logic                   stall,
  input logic                   fenceReq,
  input logic                   fenceAck,
  input logic                   memReqValid,
  input logic                   memReqReady,
  input logic [IDX_W-1:0]       memReqId,
  input logic [NUM_ENTRIES-1:0] validVec,
  input logic [NUM_ENTRIES-1:0] lineEqVec,
  input logic [NUM_ENTRIES-1:0] waitFullVec
);
  assert_no_reissue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && memReqReady |=> !(memReqValid && memReqId == $past(memReqId)));

  assert_unique_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(validVec & lineEqVec));

  assert_waiter_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    missValid && |(validVec & lineEqVec & waitFullVec) |-> stall);

  assert_stall_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    missValid && (&validVec) && !(|(validVec & lineEqVec)) |-> stall);

  assert_fence_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    missValid && fenceReq |-> stall);

  assert_fence_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fenceAck |-> validVec == '0);

  assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fenceAck |=> !fenceAck);
endmodule

bind mshrFile mshrFileChecker i_chk (
  .clk(clk), .rst_n(rst_n), .missValid(missValid), .stall(stall),
  .fenceReq(fenceReq), .fenceAck(fenceAck), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqId(memReqId), .validVec(validVec),
  .lineEqVec(lineEqVec), .waitFullVec(waitFullVec)
);

// File: tb/test_mshrFile.sv
module test_mshrFile;
  import mshrPkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic missValid = 1'b0, memReqReady = 1'b1, memRspValid = 1'b0, fenceReq = 1'b0;
  logic [LINE_W-1:0] missLine = '0;
  logic [TAG_W-1:0]  missTag = '0;
  logic [DEST_W-1:0] missDest = '0;
  logic [IDX_W-1:0]  memRspId = '0;
  logic stall, memReqValid, doneValid, fenceAck;
  logic [LINE_W-1:0] memReqLine;
  logic [IDX_W-1:0]  memReqId;
  logic [TAG_W-1:0]  doneTag;
  logic [DEST_W-1:0] doneDest;

  mshrFile i_mshrFile (.*);

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard state
  int liveW[int], attCnt[int], nextPos[int], reqCnt[int], lineId[int];
  bit inFlight[int];
  bit tagOut[64];
  int tagDest[64], tagLine[64], tagPos[64];
  int totalLive = 0, inflightNow = 0, maxInflight = 0;
  bit oooSeen = 1'b0;
  int issuedIds[$];

  // memory model state
  bit memHold = 1'b0, manValid = 1'b0;
  int manId = 0;
  bit pendOn[NUM_ENTRIES];
  int pendLat[NUM_ENTRIES];
  int nextTag = 0;

  function automatic int getReq(int ln);
    return reqCnt.exists(ln) ? reqCnt[ln] : 0;
  endfunction

  // monitor: compares completions and requests against expectations
  always @(negedge clk) begin
    int ln, t;
    if (rst_n) begin
      if (doneValid) begin
        t = int'(doneTag);
        if (!tagOut[t]) check(1'b0, "R8", "completion for tag not waiting", t, -1);
        else begin
          ln = tagLine[t];
          check(int'(doneDest) == tagDest[t], "R8", "completion destination", doneDest, tagDest[t]);
          check(tagPos[t] == nextPos[ln], "R8", "attach order", tagPos[t], nextPos[ln]);
          nextPos[ln]++;
          tagOut[t] = 1'b0;
          liveW[ln]--;
          totalLive--;
          if (liveW[ln] == 0) inFlight[ln] = 1'b0;
        end
      end
      if (memReqValid && memReqReady) begin
        ln = int'(memReqLine);
        check(liveW.exists(ln) && liveW[ln] > 0 && !(inFlight.exists(ln) && inFlight[ln]),
              "R2", "request for a line not awaiting one", ln, -1);
        inFlight[ln] = 1'b1;
        reqCnt[ln] = getReq(ln) + 1;
        lineId[ln] = int'(memReqId);
        pendOn[memReqId] = 1'b1;
        pendLat[memReqId] = 4 + (int'(memReqId) * 5) % 9;
        issuedIds.push_back(int'(memReqId));
        inflightNow++;
        if (inflightNow > maxInflight) maxInflight = inflightNow;
      end
      if (missValid && !stall) begin
        ln = int'(missLine);
        t = int'(missTag);
        if (!liveW.exists(ln) || liveW[ln] == 0) begin
          liveW[ln] = 0; attCnt[ln] = 0; nextPos[ln] = 0;
        end
        tagOut[t] = 1'b1; tagDest[t] = int'(missDest); tagLine[t] = ln;
        tagPos[t] = attCnt[ln];
        attCnt[ln]++; liveW[ln]++; totalLive++;
      end
      if (fenceAck) check(totalLive == 0, "R12", "waiters live at fence ack", totalLive, 0);
    end
  end

  task automatic respond(input int id);
    memRspValid = 1'b1;
    memRspId = IDX_W'(id);
    pendOn[id] = 1'b0;
    inflightNow--;
    if (issuedIds.size() > 0 && issuedIds[0] != id) oooSeen = 1'b1;
    foreach (issuedIds[k]) if (issuedIds[k] == id) begin issuedIds.delete(k); break; end
  endtask

  // memory model: latency per ID, youngest-index first among expired ones
  always @(posedge clk) begin
    int chosen;
    #1;
    memRspValid = 1'b0;
    if (memHold) begin
      if (manValid) begin respond(manId); manValid = 1'b0; end
    end else begin
      chosen = -1;
      for (int id = NUM_ENTRIES - 1; id >= 0; id--)
        if (pendOn[id] && pendLat[id] <= 0 && chosen < 0) chosen = id;
      for (int id = 0; id < NUM_ENTRIES; id++) if (pendOn[id]) pendLat[id]--;
      if (chosen >= 0) respond(chosen);
    end
  end

  task automatic missTry(input int ln, output bit ok);
    int t;
    t = nextTag;
    nextTag = (nextTag + 1) % 64;
    @(posedge clk); #1;
    missValid = 1'b1; missLine = LINE_W'(ln); missTag = TAG_W'(t); missDest = DEST_W'(t ^ 21);
    @(negedge clk);
    ok = !stall;
    @(posedge clk); #1;
    missValid = 1'b0;
  endtask

  task automatic waitDrain();
    for (int i = 0; i < 3000 && totalLive != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ok;
    int lA, lC, lD, lG, base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(stall == 1'b0, "R1", "stall after reset", stall, 0);
    check(memReqValid == 1'b0, "R1", "memReqValid after reset", memReqValid, 0);
    check(doneValid == 1'b0, "R1", "doneValid after reset", doneValid, 0);
    check(fenceAck == 1'b0, "R1", "fenceAck after reset", fenceAck, 0);

    // R2: single miss, byte address 0x12345680 -> line addr[31:6]
    lA = int'(32'h1234_5680 >> 6);
    missTry(lA, ok);
    check(ok, "R2", "primary miss accepted", ok, 1);
    waitDrain();
    check(getReq(lA) == 1, "R2", "requests for line", getReq(lA), 1);
    check(totalLive == 0, "R8", "waiters left after single miss", totalLive, 0);

    // R3 / R4: merging up to four waiters
    memHold = 1'b1;
    lA = 32'h0200_0000 >> 6;
    missTry(lA, ok);
    for (int i = 0; i < 3; i++) begin
      missTry(lA, ok);
      check(ok, "R3", "secondary miss accepted", ok, 1);
    end
    missTry(lA, ok);
    check(!ok, "R4", "fifth waiter stalls", ok, 0);
    check(getReq(lA) == 1, "R3", "requests for merged line", getReq(lA), 1);
    memHold = 1'b0;
    waitDrain();
    check(totalLive == 0, "R8", "waiters left after merge", totalLive, 0);

    // R5 / R6 / R7: fill all entries
    memHold = 1'b1;
    base = 32'h0400_0000 >> 6;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      missTry(base + i * 3, ok);
      check(ok, "R6", "distinct-line miss accepted", ok, 1);
    end
    repeat (3) @(negedge clk);
    missTry(base + 1000, ok);
    check(!ok, "R5", "new line with file full stalls", ok, 0);
    missTry(base, ok);
    check(ok, "R5", "merge with file full accepted", ok, 1);
    check(maxInflight >= NUM_ENTRIES, "R6", "requests outstanding at once", maxInflight, NUM_ENTRIES);
    memHold = 1'b0;
    waitDrain();
    check(oooSeen, "R7", "out-of-order response completed", oooSeen, 1);
    check(totalLive == 0, "R8", "waiters left after full file", totalLive, 0);

    // R11 / R9: miss during completion drain, then reallocation
    memHold = 1'b1;
    lC = 32'h0800_0040 >> 6;
    for (int i = 0; i < 3; i++) missTry(lC, ok);
    repeat (2) @(negedge clk);
    manId = lineId[lC]; manValid = 1'b1;
    @(posedge clk);
    missTry(lC, ok);
    check(!ok, "R11", "miss while entry drains stalls", ok, 0);
    waitDrain();
    missTry(lC, ok);
    check(ok, "R9", "miss after free accepted", ok, 1);
    repeat (3) @(negedge clk);
    check(getReq(lC) == 2, "R9", "fresh request after free", getReq(lC), 2);
    manId = lineId[lC]; manValid = 1'b1;
    waitDrain();

    // R10: miss in the same cycle as the line's response
    lD = 32'h0900_0080 >> 6;
    missTry(lD, ok);
    repeat (2) @(negedge clk);
    manId = lineId[lD]; manValid = 1'b1;
    missTry(lD, ok);
    check(ok, "R10", "same-cycle miss merged", ok, 1);
    waitDrain();
    check(getReq(lD) == 1, "R10", "requests for line", getReq(lD), 1);
    check(totalLive == 0, "R10", "waiters left", totalLive, 0);

    // R12: fence with misses in flight
    missTry(32'h0a00_0000 >> 6, ok);
    missTry(32'h0a00_1000 >> 6, ok);
    repeat (2) @(negedge clk);
    lG = 32'h0b00_0000 >> 6;
    @(posedge clk); #1;
    fenceReq = 1'b1; missValid = 1'b1; missLine = LINE_W'(lG); missTag = TAG_W'(nextTag);
    @(negedge clk);
    check(stall == 1'b1, "R12", "miss in fence cycle stalls", stall, 1);
    @(posedge clk); #1;
    fenceReq = 1'b0; missValid = 1'b0;
    missTry(lG, ok);
    check(!ok, "R12", "miss while fence pending stalls", ok, 0);
    memHold = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 500 && !ok; i++) begin
      @(negedge clk);
      ok = fenceAck;
    end
    check(ok, "R12", "fence acknowledged", ok, 1);
    @(negedge clk);
    check(fenceAck == 1'b0, "R12", "ack is one cycle", fenceAck, 0);
    missTry(lG, ok);
    check(ok, "R12", "miss after ack accepted", ok, 1);
    waitDrain();

    // R12: fence with nothing outstanding
    @(posedge clk); #1 fenceReq = 1'b1;
    @(posedge clk); #1 fenceReq = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 4 && !ok; i++) begin
      @(negedge clk);
      ok = fenceAck;
    end
    check(ok, "R12", "empty fence acknowledged", ok, 1);
    check(totalLive == 0, "R8", "waiters never completed", totalLive, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule